// File: doc/BRIEF.md
# Separable Input-First Virtual Channel Allocator

This block hands out output virtual channels to input virtual channels inside a packet router that has `P` ports and `V` virtual channels on each port. Every input VC that wants an output VC presents one destination port and a `V`-bit mask of the channels it would accept there. Two rounds of rotating-priority arbitration settle the matching. First, each input VC picks a single candidate from its own eligible channels. Then each output VC picks one winner among the input VCs that chose it. An input VC only ever targets one port, so the grants that return to it from all ports are merged with an OR.

The block keeps an ownership table for the output VCs. A granted output VC turns busy and records the flat index of the input VC that owns it. The winning input VC moves to a held state and latches the index of the VC it was given at its port. When the tail of the packet has left, a release pulse on the output VC returns both the output VC and its owner to the free pool. An optional class mode groups the VCs into disjoint packet classes. A permission matrix then states which output classes each input class may move into.

Each input VC has a two-state machine, IDLE and HELD. The GRANT transition takes IDLE to HELD, and the RELEASE transition takes HELD back to IDLE. Each output VC has a two-state machine, FREE and BUSY, with the TAKE transition from FREE to BUSY and the FREE-UP transition from BUSY back to FREE.

Top module: `vc_alloc_sep`

## Requirements
- R1: A synchronous reset marks every output VC free and every input VC idle, clears all grant pulses, and sets every arbiter pointer to index 0. The first contention after reset is therefore won by the lowest index.
- R2: Input VC `i` has flat index port*V + vc. It makes a request in a cycle only when it is idle, its valid bit is high and its destination port is below `P`. The channels it may use are its mask ANDed with the free output VCs at that port and with the class-allowed channels. Of these, its local arbiter picks exactly one candidate, searching upward from its pointer and wrapping around.
- R3: Each output VC `o` (port o/V, channel o%V) picks one winner among the input VCs whose candidate is `o`. It searches upward from its pointer over the flat input index and wraps around. The winner's `gnt` bit pulses high for one cycle, starting at the edge that ends the request cycle.
- R4: In any cycle, at most one input VC is granted per output VC, at most one output VC is granted per input VC, and a busy output VC is never granted.
- R5: On a grant to output VC `o`, after the same edge, `ovc_busy[o]` is 1, the owner field of `o` holds the winner's flat index, `ivc_done` of the winner is 1, and the winner's `ivc_ovc` field holds o%V.
- R6: After a grant, the output arbiter's pointer moves to winner+1, wrapping at P*V, and the winning input's local pointer moves to channel+1, wrapping at V. An input's local pointer does not move in cycles where that input is not granted.
- R7: In class mode, the class of channel `v` is v*NCLS/V for both input and output VCs. An output channel of class `oc` is allowed for an input channel of class `ic` only if bit ic*NCLS+oc of `CLASS_ALLOW` is 1. The defaults are NCLS=2 and `CLASS_ALLOW`=4'b1101: class 0 may use only class 0, and class 1 may use both classes.
- R8: A release pulse on a busy output VC frees it at the next edge and returns its owner input VC to idle at that same edge. A release pulse on a free output VC changes nothing.
- R9: A held input VC ignores its request inputs, and its latched channel index stays constant until release. A request whose port value is P or higher is ignored.
- R10: An output VC that receives a release pulse is still busy during that cycle, so it cannot be granted until the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | P*V | Request valid per input VC |
| req_port | input | P*V*PW | Destination port per input VC, PW=clog2(P) bits each |
| req_mask | input | P*V*V | Acceptable output channels at the destination, V bits per input VC |
| ovc_release | input | P*V | Tail release pulse per output VC |
| gnt | output | P*V | One-cycle grant pulse per input VC |
| ivc_done | output | P*V | Input VC is in the HELD state |
| ivc_ovc | output | P*V*VW | Latched output channel index per input VC |
| ovc_busy | output | P*V | Output VC is in the BUSY state |
| ovc_owner | output | P*V*IW | Flat input VC index that owns each output VC |

## Verification
The hardest situation to reach is when several input VCs contend for one output VC just as that VC is released. In that case the pointer must have moved past the previous winner, and the released VC must stay unavailable for one cycle. Directed steps build this case exactly: two inputs collide, the owner is released while the loser keeps asking, and then both ask again. Seeded random traffic follows. Ten inputs aim at only five ports, and release pulses arrive often and at random, so collisions, pointer wrap-around, releases of free VCs and invalid port values all recur many times. Each cycle is compared against a reference model in the bench.

// File: rtl/vca_pkg.sv
package vca_pkg;

    typedef enum logic {
        IVC_IDLE = 1'b0,
        IVC_HELD = 1'b1
    } ivc_state_e;

    typedef enum logic {
        OVC_FREE = 1'b0,
        OVC_BUSY = 1'b1
    } ovc_state_e;

endpackage

// File: rtl/vca_rr_arb.sv
module vca_rr_arb #(
    parameter int N = 4,
    localparam int PTRW = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         upd,
    output logic [N-1:0] gnt
);

    logic [PTRW-1:0] ptr;
    logic [PTRW-1:0] win_idx;
    logic            found;

    // search upward from the pointer, wrapping around
    always_comb begin
        gnt     = '0;
        win_idx = '0;
        found   = 1'b0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(ptr) + k) % N;
            if (!found && req[idx]) begin
                found      = 1'b1;
                gnt[idx]   = 1'b1;
                win_idx    = PTRW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (upd && found) begin
            ptr <= (int'(win_idx) == N - 1) ? '0 : PTRW'(int'(win_idx) + 1);
        end
    end

endmodule

// File: rtl/vca_ivc_ctrl.sv
module vca_ivc_ctrl
    import vca_pkg::*;
#(
    parameter int VW = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          win,
    input  logic [VW-1:0] win_vc,
    input  logic          rel_hit,
    output logic          done,
    output logic [VW-1:0] vc_idx,
    output logic          gnt_pulse
);

    ivc_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            IVC_IDLE: if (win)     state_nx = IVC_HELD;   // GRANT
            IVC_HELD: if (rel_hit) state_nx = IVC_IDLE;   // RELEASE
            default:               state_nx = IVC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= IVC_IDLE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vc_idx    <= '0;
            gnt_pulse <= 1'b0;
        end else begin
            gnt_pulse <= (state == IVC_IDLE) && win;
            if ((state == IVC_IDLE) && win) vc_idx <= win_vc;
        end
    end

    assign done = (state == IVC_HELD);

endmodule

// File: rtl/vca_ovc_ctrl.sv
module vca_ovc_ctrl
    import vca_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic [IW-1:0] take_idx,
    input  logic          rel,
    output logic          busy,
    output logic [IW-1:0] owner
);

    ovc_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            OVC_FREE: if (take) state_nx = OVC_BUSY;   // TAKE
            OVC_BUSY: if (rel)  state_nx = OVC_FREE;   // FREE-UP
            default:            state_nx = OVC_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= OVC_FREE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owner <= '0;
        end else if ((state == OVC_FREE) && take) begin
            owner <= take_idx;
        end
    end

    assign busy = (state == OVC_BUSY);

endmodule

// File: rtl/vc_alloc_sep.sv
module vc_alloc_sep
    import vca_pkg::*;
#(
    parameter int P         = 5,
    parameter int V         = 2,
    parameter int SPARSE_EN = 1,
    parameter int NCLS      = 2,
    parameter logic [NCLS*NCLS-1:0] CLASS_ALLOW = 4'b1101,
    localparam int NI = P * V,
    localparam int PW = (P > 1) ? $clog2(P) : 1,
    localparam int VW = (V > 1) ? $clog2(V) : 1,
    localparam int IW = (NI > 1) ? $clog2(NI) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NI-1:0]    req_valid,
    input  logic [NI*PW-1:0] req_port,
    input  logic [NI*V-1:0]  req_mask,
    input  logic [NI-1:0]    ovc_release,
    output logic [NI-1:0]    gnt,
    output logic [NI-1:0]    ivc_done,
    output logic [NI*VW-1:0] ivc_ovc,
    output logic [NI-1:0]    ovc_busy,
    output logic [NI*IW-1:0] ovc_owner
);

    logic [NI-1:0][V-1:0]  elig;
    logic [NI-1:0][V-1:0]  cand;
    logic [NI-1:0][V-1:0]  wv;
    logic [NI-1:0][NI-1:0] oreq;
    logic [NI-1:0][NI-1:0] og;
    logic [NI-1:0]         won;
    logic [NI-1:0]         rel_hit;
    logic [NI-1:0][VW-1:0] win_vc;
    logic [NI-1:0][IW-1:0] take_idx;
    logic [NI-1:0]         take;
    logic [P-1:0][V-1:0]   busy_pp;

    assign busy_pp = ovc_busy;

    function automatic logic [V-1:0] class_mask(int ivc_local);
        logic [V-1:0] m;
        int ic;
        int oc;
        m = '1;
        if (SPARSE_EN != 0) begin
            ic = ivc_local * NCLS / V;
            for (int v = 0; v < V; v++) begin
                oc   = v * NCLS / V;
                m[v] = CLASS_ALLOW[ic*NCLS+oc];
            end
        end
        return m;
    endfunction

    // eligible output channels per input VC
    always_comb begin
        for (int i = 0; i < NI; i++) begin
            logic [PW-1:0] pt;
            pt      = req_port[i*PW +: PW];
            elig[i] = '0;
            if (req_valid[i] && !ivc_done[i] && (int'(pt) < P)) begin
                elig[i] = req_mask[i*V +: V] & ~busy_pp[pt] & class_mask(i % V);
            end
        end
    end

    // input-side arbitration: one candidate channel per input VC
    for (genvar gi = 0; gi < NI; gi++) begin : g_in_arb
        vca_rr_arb #(.N(V)) u_arb (
            .clk (clk),
            .rst (rst),
            .req (elig[gi]),
            .upd (won[gi]),
            .gnt (cand[gi])
        );
    end

    // requests seen by every output VC
    always_comb begin
        for (int o = 0; o < NI; o++) begin
            for (int i = 0; i < NI; i++) begin
                oreq[o][i] = cand[i][o % V] &&
                             (int'(req_port[i*PW +: PW]) == (o / V));
            end
        end
    end

    // output-side arbitration
    for (genvar go = 0; go < NI; go++) begin : g_out_arb
        vca_rr_arb #(.N(NI)) u_arb (
            .clk (clk),
            .rst (rst),
            .req (oreq[go]),
            .upd (1'b1),
            .gnt (og[go])
        );
    end

    // merge grants from all ports back to each input VC
    always_comb begin
        for (int i = 0; i < NI; i++) begin
            wv[i]     = '0;
            win_vc[i] = '0;
            for (int v = 0; v < V; v++) begin
                for (int p = 0; p < P; p++) begin
                    wv[i][v] = wv[i][v] | og[p*V+v][i];
                end
                if (wv[i][v]) win_vc[i] = VW'(v);
            end
            won[i] = |wv[i];
        end
    end

    always_comb begin
        for (int o = 0; o < NI; o++) begin
            take[o]     = |og[o];
            take_idx[o] = '0;
            for (int i = 0; i < NI; i++) begin
                if (og[o][i]) take_idx[o] = IW'(i);
            end
        end
    end

    // release routed to the owning input VC
    always_comb begin
        for (int i = 0; i < NI; i++) begin
            rel_hit[i] = 1'b0;
            for (int o = 0; o < NI; o++) begin
                if (ovc_release[o] && ovc_busy[o] &&
                    (ovc_owner[o*IW +: IW] == IW'(i))) begin
                    rel_hit[i] = 1'b1;
                end
            end
        end
    end

    for (genvar gi = 0; gi < NI; gi++) begin : g_ivc
        vca_ivc_ctrl #(.VW(VW)) u_ivc (
            .clk       (clk),
            .rst       (rst),
            .win       (won[gi]),
            .win_vc    (win_vc[gi]),
            .rel_hit   (rel_hit[gi]),
            .done      (ivc_done[gi]),
            .vc_idx    (ivc_ovc[gi*VW +: VW]),
            .gnt_pulse (gnt[gi])
        );
    end

    for (genvar go = 0; go < NI; go++) begin : g_ovc
        vca_ovc_ctrl #(.IW(IW)) u_ovc (
            .clk      (clk),
            .rst      (rst),
            .take     (take[go]),
            .take_idx (take_idx[go]),
            .rel      (ovc_release[go]),
            .busy     (ovc_busy[go]),
            .owner    (ovc_owner[go*IW +: IW])
        );
    end

endmodule

// File: rtl/vca_checker.sv
module vca_checker #(
    parameter int P = 5,
    parameter int V = 2,
    localparam int NI = P * V,
    localparam int VW = (V > 1) ? $clog2(V) : 1,
    localparam int IW = (NI > 1) ? $clog2(NI) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic [NI-1:0]    gnt,
    input logic [NI-1:0]    ivc_done,
    input logic [NI*VW-1:0] ivc_ovc,
    input logic [NI-1:0]    ovc_busy,
    input logic [NI*IW-1:0] ovc_owner,
    input logic [NI-1:0]    ovc_release,
    input logic [NI*NI-1:0] og_flat
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (ovc_busy == '0) && (ivc_done == '0) && (gnt == '0));

    a_r5_busy_count_matches: assert property (@(posedge clk) disable iff (rst)
        $countones(ovc_busy) == $countones(ivc_done));

    for (genvar o = 0; o < NI; o++) begin : g_o
        a_r4_one_winner_per_ovc: assert property (@(posedge clk) disable iff (rst)
            $onehot0(og_flat[o*NI +: NI]));

        a_r4_busy_not_granted: assert property (@(posedge clk) disable iff (rst)
            ovc_busy[o] |-> (og_flat[o*NI +: NI] == '0));

        a_r8_release_frees: assert property (@(posedge clk) disable iff (rst)
            (ovc_release[o] && ovc_busy[o]) |=> !ovc_busy[o]);

        a_r10_busy_holds_owner: assert property (@(posedge clk) disable iff (rst)
            (ovc_busy[o] && !ovc_release[o]) |=>
                (ovc_busy[o] && $stable(ovc_owner[o*IW +: IW])));
    end

    for (genvar i = 0; i < NI; i++) begin : g_i
        a_r5_grant_sets_held: assert property (@(posedge clk) disable iff (rst)
            gnt[i] |-> ivc_done[i]);

        a_r9_held_index_stable: assert property (@(posedge clk) disable iff (rst)
            (ivc_done[i] && (ovc_release == '0)) |=>
                (ivc_done[i] && $stable(ivc_ovc[i*VW +: VW])));
    end

endmodule

bind vc_alloc_sep vca_checker #(.P(P), .V(V)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .gnt         (gnt),
    .ivc_done    (ivc_done),
    .ivc_ovc     (ivc_ovc),
    .ovc_busy    (ovc_busy),
    .ovc_owner   (ovc_owner),
    .ovc_release (ovc_release),
    .og_flat     (og)
);

// File: tb/vc_alloc_sep_bench.sv
module vc_alloc_sep_bench;

    localparam int P    = 5;
    localparam int V    = 2;
    localparam int NI   = P * V;
    localparam int PW   = 3;
    localparam int VW   = 1;
    localparam int IW   = 4;
    localparam int NCLS = 2;
    localparam logic [3:0] ALLOW = 4'b1101;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NI-1:0]    req_valid = '0;
    logic [NI*PW-1:0] req_port = '0;
    logic [NI*V-1:0]  req_mask = '0;
    logic [NI-1:0]    ovc_release = '0;
    logic [NI-1:0]    gnt;
    logic [NI-1:0]    ivc_done;
    logic [NI*VW-1:0] ivc_ovc;
    logic [NI-1:0]    ovc_busy;
    logic [NI*IW-1:0] ovc_owner;

    int n_tests = 0;
    int n_fail  = 0;

    int m_busy[NI];
    int m_owner[NI];
    int m_done[NI];
    int m_vc[NI];
    int m_gnt[NI];
    int m_inptr[NI];
    int m_outptr[NI];

    always #5 clk = ~clk;

    vc_alloc_sep u_vc_alloc_sep (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_port    (req_port),
        .req_mask    (req_mask),
        .ovc_release (ovc_release),
        .gnt         (gnt),
        .ivc_done    (ivc_done),
        .ivc_ovc     (ivc_ovc),
        .ovc_busy    (ovc_busy),
        .ovc_owner   (ovc_owner)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit allowed(int ivl, int v);
        int ic = ivl * NCLS / V;
        int oc = v * NCLS / V;
        return ALLOW[ic*NCLS+oc];
    endfunction

    task automatic model_reset();
        for (int k = 0; k < NI; k++) begin
            m_busy[k] = 0; m_owner[k] = 0; m_done[k] = 0; m_vc[k] = 0;
            m_gnt[k] = 0; m_inptr[k] = 0; m_outptr[k] = 0;
        end
    endtask

    // reference behaviour for one clock edge, from current inputs
    task automatic model_step();
        int cand[NI];
        int win[NI];
        int prt[NI];
        for (int i = 0; i < NI; i++) begin
            prt[i]  = int'(req_port[i*PW +: PW]);
            cand[i] = -1;
            if (req_valid[i] && m_done[i] == 0 && prt[i] < P) begin
                for (int k = 0; k < V; k++) begin
                    int v = (m_inptr[i] + k) % V;
                    if (cand[i] < 0 && req_mask[i*V+v] && m_busy[prt[i]*V+v] == 0
                        && allowed(i % V, v))
                        cand[i] = v;
                end
            end
        end
        for (int o = 0; o < NI; o++) begin
            win[o] = -1;
            for (int k = 0; k < NI; k++) begin
                int i = (m_outptr[o] + k) % NI;
                if (win[o] < 0 && cand[i] == o % V && prt[i] == o / V) win[o] = i;
            end
        end
        for (int k = 0; k < NI; k++) m_gnt[k] = 0;
        for (int o = 0; o < NI; o++) begin
            if (ovc_release[o] && m_busy[o] != 0) begin
                m_busy[o] = 0;
                m_done[m_owner[o]] = 0;
            end
        end
        for (int o = 0; o < NI; o++) begin
            if (win[o] >= 0) begin
                m_busy[o] = 1;
                m_owner[o] = win[o];
                m_done[win[o]] = 1;
                m_vc[win[o]] = o % V;
                m_gnt[win[o]] = 1;
                m_outptr[o] = (win[o] + 1) % NI;
                m_inptr[win[o]] = (o % V + 1) % V;
            end
        end
    endtask

    task automatic compare_all(string tag);
        for (int i = 0; i < NI; i++) begin
            chk({tag, " R3"}, $sformatf("gnt[%0d]", i), int'(gnt[i]), m_gnt[i]);
            chk({tag, " R5"}, $sformatf("ivc_done[%0d]", i), int'(ivc_done[i]), m_done[i]);
            if (m_done[i] != 0)
                chk({tag, " R9"}, $sformatf("ivc_ovc[%0d]", i), int'(ivc_ovc[i*VW +: VW]), m_vc[i]);
        end
        for (int o = 0; o < NI; o++) begin
            chk({tag, " R8"}, $sformatf("ovc_busy[%0d]", o), int'(ovc_busy[o]), m_busy[o]);
            if (m_busy[o] != 0)
                chk({tag, " R5"}, $sformatf("ovc_owner[%0d]", o), int'(ovc_owner[o*IW +: IW]), m_owner[o]);
        end
    endtask

    // called at a negative edge with inputs already driven
    task automatic cycle(string tag);
        model_step();
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic set_req(int i, int port, int mask);
        req_valid[i] = 1'b1;
        req_port[i*PW +: PW] = PW'(port);
        req_mask[i*V +: V] = V'(mask);
    endtask

    task automatic clear_inputs();
        req_valid = '0;
        req_port = '0;
        req_mask = '0;
        ovc_release = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", "gnt", int'(gnt), 0);
        chk("R1", "ivc_done", int'(ivc_done), 0);
        chk("R1", "ovc_busy", int'(ovc_busy), 0);

        // R1/R3: two inputs collide on output VC 4, lowest index wins after reset
        set_req(0, 2, 1);
        set_req(2, 2, 1);
        cycle("R1");
        chk("R3", "gnt contention", int'(gnt), 1);
        chk("R5", "owner of ovc4", int'(ovc_owner[4*IW +: IW]), 0);

        // R9/R4: held input ignored, busy VC not granted to the loser
        cycle("R4");
        chk("R4", "gnt while busy", int'(gnt), 0);
        chk("R9", "input 0 still held", int'(ivc_done[0]), 1);

        // R10: release pulse, loser still asking, no grant this cycle
        ovc_release[4] = 1'b1;
        cycle("R10");
        chk("R10", "gnt on release cycle", int'(gnt), 0);
        chk("R8", "ovc4 freed", int'(ovc_busy[4]), 0);
        chk("R8", "input 0 idle", int'(ivc_done[0]), 0);

        // R6: both ask again, pointer now past input 0
        ovc_release[4] = 1'b0;
        cycle("R6");
        chk("R6", "rotated winner", int'(gnt), 32'h4);

        // R7: class-1 input may use class 0; class-0 input barred from class 1
        clear_inputs();
        set_req(1, 3, 3);
        set_req(4, 3, 2);
        cycle("R7");
        chk("R7", "class grants", int'(gnt), 32'h2);
        chk("R7", "class-1 input got channel 0", int'(ivc_ovc[1*VW +: VW]), 0);

        // R9: port value at or above P is ignored; R8 release of a free VC ignored
        clear_inputs();
        set_req(5, 5, 3);
        ovc_release[0] = 1'b1;
        cycle("R9");
        chk("R9", "bad port no grant", int'(gnt), 0);
        chk("R8", "free release ignored", int'(ovc_busy), 32'h50);

        // R2: input with both channels eligible takes its pointer's first choice
        clear_inputs();
        ovc_release[4] = 1'b1;
        ovc_release[6] = 1'b1;
        cycle("R8");
        clear_inputs();
        set_req(3, 1, 3);
        cycle("R2");
        chk("R2", "single candidate", int'(gnt), 32'h8);
        chk("R2", "channel from pointer", int'(ivc_ovc[3*VW +: VW]), 0);

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            clear_inputs();
            for (int i = 0; i < NI; i++) begin
                if ($urandom % 2 == 0) set_req(i, int'($urandom % 6), int'($urandom % 4));
                if ($urandom % 6 == 0) ovc_release[i] = 1'b1;
            end
            cycle("RAND");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule